// File: doc/BRIEF.md
# Masked Dual-Rail Precharge 4-bit Substitution Box

This block evaluates a fixed 4-bit substitution (the PRESENT S-box) on a network of dual-rail precharge gates. Every logical bit travels as a pair of wires, a true rail and a false rail. During a precharge cycle both rails of every pair sit low. During an evaluation cycle exactly one rail of each pair is high. A single mask bit is shared by the whole network and is carried as its own rail pair. It inverts every value in the network, which is the same as swapping the two rails of every pair. As a result, the rail that toggles no longer depends on the data alone.

The block alternates precharge and evaluation cycles. At the end of precharge it samples the input nibble and XORs it with the current mask bit. That masked nibble is spread onto rail pairs for the evaluation cycle. At the end of evaluation the output rails are unmasked into a registered result and a valid pulse is raised. The mask generator then steps once, so every evaluation sees a fresh mask bit. Per-rail rise counters on the four output pairs let a user confirm that both rails of each pair see similar activity.

Top module: `masked_drp_sbox`

## Requirements
- R1: After reset the block is in a precharge cycle (`eval_o`=0). From then on, precharge and evaluation cycles strictly alternate, one clock cycle each.
- R2: In every precharge cycle all eight output rails (`rail_t_o`, `rail_f_o`) are low.
- R3: In every evaluation cycle each output pair has exactly one rail high. `rail_t_o[i]` equals bit i of S(x) XOR the mask bit, where x is the nibble sampled at the end of the preceding precharge cycle.
- R4: In the cycle after each evaluation, `dout_o` equals S(x). S is the table 0→C, 1→5, 2→6, 3→B, 4→9, 5→0, 6→A, 7→D, 8→3, 9→E, A→F, B→8, C→4, D→7, E→1, F→2. This holds for all 16 inputs under both mask values.
- R5: `out_valid_o` is high for exactly the one cycle that follows each evaluation cycle and is low otherwise. `dout_o` holds its value until the next result.
- R6: The mask comes from a 64-bit shift register. It shifts left, and a new bit 0 is formed as the XOR of bits 63, 62, 60 and 59. `mask_o` is bit 0. Reset loads the seed (default 64'h0123456789ABCDEF, so `mask_o`=1 after reset). The register steps once at each clock edge that ends an evaluation cycle.
- R7: The mask is stable from a precharge cycle through the evaluation cycle that follows it. `din` is sampled only at the edge that ends a precharge cycle, and changes to `din` during evaluation have no effect on the result.
- R8: `cnt_t_o[i*CNT_W +: CNT_W]` counts the evaluations in which the true rail of output bit i was high. `cnt_f_o` counts the same for the false rail. For each bit the two counts sum to the number of evaluations since reset.
- R9: Reset clears `dout_o`, `out_valid_o` and all rise counters to zero and reloads the mask seed, including when it is applied in the middle of operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 4 | Plain input nibble, sampled at the end of precharge |
| eval_o | output | 1 | 1 during an evaluation cycle, 0 during precharge |
| mask_o | output | 1 | Current shared mask bit |
| rail_t_o | output | 4 | True rails of the masked output pairs |
| rail_f_o | output | 4 | False rails of the masked output pairs |
| dout_o | output | 4 | Registered unmasked result |
| out_valid_o | output | 1 | One-cycle pulse when a new result is in `dout_o` |
| cnt_t_o | output | 4*CNT_W | Rise counts of the true rails, bit i in field i |
| cnt_f_o | output | 4*CNT_W | Rise counts of the false rails, bit i in field i |

## Verification
The bench builds the block with its default parameters: the 64-bit mask register with its standard seed and taps, and 16-bit rise counters. With these values the mask sequence is known in advance, so the bench can choose which input to apply next. It steers the stimulus until every one of the 16 inputs has been seen under mask 0 and under mask 1. The counters cannot wrap within the run, so exact per-rail rise totals can be predicted and compared. A mid-run reset confirms that the seed and the counters return to their initial values.

// File: rtl/msbox_pkg.sv
package msbox_pkg;

    localparam int NBITS  = 4;
    localparam int NINPUT = 1 << NBITS;
    localparam int NLEAF  = NINPUT / 2;
    localparam int NNODE  = NINPUT - 1;

    // One dual-rail signal: t is the true rail, f the false rail.
    typedef struct packed {
        logic t;
        logic f;
    } rail_pair_t;

    typedef enum logic {
        G_AND = 1'b0,
        G_XOR = 1'b1
    } gate_kind_e;

    // Plain substitution table of the evaluated function.
    function automatic logic [NBITS-1:0] sbox_fwd(input logic [NBITS-1:0] x);
        logic [NBITS-1:0] r;
        case (x)
            4'h0: r = 4'hC;
            4'h1: r = 4'h5;
            4'h2: r = 4'h6;
            4'h3: r = 4'hB;
            4'h4: r = 4'h9;
            4'h5: r = 4'h0;
            4'h6: r = 4'hA;
            4'h7: r = 4'hD;
            4'h8: r = 4'h3;
            4'h9: r = 4'hE;
            4'hA: r = 4'hF;
            4'hB: r = 4'h8;
            4'hC: r = 4'h4;
            4'hD: r = 4'h7;
            4'hE: r = 4'h1;
            default: r = 4'h2;
        endcase
        return r;
    endfunction

    // Inversion in dual-rail form is a plain exchange of the rails.
    function automatic rail_pair_t rail_swap(input rail_pair_t r);
        rail_pair_t o;
        o.t = r.f;
        o.f = r.t;
        return o;
    endfunction

endpackage

// File: rtl/mdr_gate.sv
module mdr_gate
    import msbox_pkg::*;
#(
    parameter gate_kind_e KIND = G_AND
) (
    input  rail_pair_t a,
    input  rail_pair_t b,
    input  rail_pair_t m,
    output rail_pair_t y
);

    logic       ready;
    rail_pair_t raw;

    // Evaluation waits until every input pair, mask included, is complementary.
    assign ready = (a.t ^ a.f) & (b.t ^ b.f) & (m.t ^ m.f);

    generate
        if (KIND == G_AND) begin : g_and
            // mask 0: plain AND; mask 1: the inverted-domain AND is an OR of the masked rails
            always_comb begin
                raw.t = (m.f & a.t & b.t) | (m.t & (a.t | b.t));
                raw.f = (m.f & (a.f | b.f)) | (m.t & a.f & b.f);
            end
        end else begin : g_xor
            logic xt;
            logic xf;
            assign xt = (a.t & b.f) | (a.f & b.t);
            assign xf = (a.t & b.t) | (a.f & b.f);
            // two masked operands carry the mask twice; fold it back in once
            always_comb begin
                raw.t = (xt & m.f) | (xf & m.t);
                raw.f = (xt & m.t) | (xf & m.f);
            end
        end
    endgenerate

    assign y.t = ready & raw.t;
    assign y.f = ready & raw.f;

endmodule

// File: rtl/msbox_bit.sv
module msbox_bit
    import msbox_pkg::*;
#(
    parameter int BIT = 0
) (
    input  rail_pair_t [NBITS-1:0] x,
    input  rail_pair_t             m,
    output rail_pair_t             y
);

    // Heap-ordered tree: nodes 0..NLEAF-1 are leaves over x[0],
    // node NLEAF+u is a multiplexer of nodes 2u and 2u+1.
    rail_pair_t node [NNODE];

    genvar j;
    generate
        for (j = 0; j < NLEAF; j++) begin : g_leaf
            localparam logic [NBITS-1:0] V0 = sbox_fwd(NBITS'(2 * j));
            localparam logic [NBITS-1:0] V1 = sbox_fwd(NBITS'(2 * j + 1));
            localparam logic C0 = V0[BIT];
            localparam logic C1 = V1[BIT];
            rail_pair_t kconst;
            // a masked constant c is the mask pair itself, swapped when c = 1
            assign kconst = C0 ? rail_swap(m) : m;
            if (C0 == C1) begin : g_const
                assign node[j] = kconst;
            end else begin : g_var
                mdr_gate #(.KIND(G_XOR)) u_x (
                    .a (x[0]),
                    .b (kconst),
                    .m (m),
                    .y (node[j])
                );
            end
        end

        for (j = 0; j < NNODE - NLEAF; j++) begin : g_mux
            localparam int SEL = (j < NLEAF / 2) ? 1 : ((j < NLEAF / 2 + NLEAF / 4) ? 2 : 3);
            rail_pair_t s_n;
            rail_pair_t p_hi;
            rail_pair_t p_lo;
            rail_pair_t or_y;
            assign s_n = rail_swap(x[SEL]);
            mdr_gate #(.KIND(G_AND)) u_hi (
                .a (x[SEL]),
                .b (node[2*j+1]),
                .m (m),
                .y (p_hi)
            );
            mdr_gate #(.KIND(G_AND)) u_lo (
                .a (s_n),
                .b (node[2*j]),
                .m (m),
                .y (p_lo)
            );
            // OR gate: AND cell with input and output rails exchanged
            mdr_gate #(.KIND(G_AND)) u_or (
                .a (rail_swap(p_hi)),
                .b (rail_swap(p_lo)),
                .m (m),
                .y (or_y)
            );
            assign node[NLEAF+j] = rail_swap(or_y);
        end
    endgenerate

    assign y = node[NNODE-1];

endmodule

// File: rtl/mask_lfsr.sv
module mask_lfsr #(
    parameter int           W    = 64,
    parameter logic [W-1:0] TAPS = 64'hD800_0000_0000_0000,
    parameter logic [W-1:0] SEED = 64'h0123_4567_89AB_CDEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic bit_o
);

    logic [W-1:0] sr_d;
    logic [W-1:0] sr_q;

    always_comb begin
        sr_d = sr_q;
        if (step) begin
            sr_d = {sr_q[W-2:0], ^(sr_q & TAPS)};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= SEED;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign bit_o = sr_q[0];

endmodule

// File: rtl/masked_drp_sbox.sv
module masked_drp_sbox
    import msbox_pkg::*;
#(
    parameter int                LFSR_W    = 64,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 64'hD800_0000_0000_0000,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 64'h0123_4567_89AB_CDEF,
    parameter int                CNT_W     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NBITS-1:0]       din,
    output logic                   eval_o,
    output logic                   mask_o,
    output logic [NBITS-1:0]       rail_t_o,
    output logic [NBITS-1:0]       rail_f_o,
    output logic [NBITS-1:0]       dout_o,
    output logic                   out_valid_o,
    output logic [NBITS*CNT_W-1:0] cnt_t_o,
    output logic [NBITS*CNT_W-1:0] cnt_f_o
);

    localparam int CW_ALL = NBITS * CNT_W;

    typedef struct packed {
        logic              eval;
        logic [NBITS-1:0]  in_m;
        logic [NBITS-1:0]  dout;
        logic              vld;
        logic [CW_ALL-1:0] ct;
        logic [CW_ALL-1:0] cf;
    } state_t;

    state_t s_d;
    state_t s_q;

    logic                    mask;
    rail_pair_t              m_rail;
    rail_pair_t [NBITS-1:0]  x_rail;
    rail_pair_t [NBITS-1:0]  y_rail;

    // Mask advances at the edge that closes evaluation.
    mask_lfsr #(
        .W    (LFSR_W),
        .TAPS (LFSR_TAPS),
        .SEED (LFSR_SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (s_q.eval),
        .bit_o (mask)
    );

    // Precharge: every driven pair, mask included, is forced to 00.
    always_comb begin
        m_rail.t = s_q.eval & mask;
        m_rail.f = s_q.eval & ~mask;
        for (int i = 0; i < NBITS; i++) begin
            x_rail[i].t = s_q.eval & s_q.in_m[i];
            x_rail[i].f = s_q.eval & ~s_q.in_m[i];
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NBITS; gi++) begin : g_out
            msbox_bit #(.BIT(gi)) u_bit (
                .x (x_rail),
                .m (m_rail),
                .y (y_rail[gi])
            );
        end
    endgenerate

    always_comb begin
        s_d      = s_q;
        s_d.eval = ~s_q.eval;
        s_d.vld  = 1'b0;
        if (!s_q.eval) begin
            s_d.in_m = din ^ {NBITS{mask}};
        end else begin
            s_d.vld = 1'b1;
            for (int i = 0; i < NBITS; i++) begin
                s_d.dout[i] = y_rail[i].t ^ mask;
                s_d.ct[i*CNT_W +: CNT_W] = s_q.ct[i*CNT_W +: CNT_W] + CNT_W'(y_rail[i].t);
                s_d.cf[i*CNT_W +: CNT_W] = s_q.cf[i*CNT_W +: CNT_W] + CNT_W'(y_rail[i].f);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        for (int i = 0; i < NBITS; i++) begin
            rail_t_o[i] = y_rail[i].t;
            rail_f_o[i] = y_rail[i].f;
        end
    end

    assign eval_o      = s_q.eval;
    assign mask_o      = mask;
    assign dout_o      = s_q.dout;
    assign out_valid_o = s_q.vld;
    assign cnt_t_o     = s_q.ct;
    assign cnt_f_o     = s_q.cf;

endmodule

// File: rtl/msbox_checker.sv
module msbox_checker #(
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          eval_o,
    input logic          mask_o,
    input logic [NB-1:0] rail_t_o,
    input logic [NB-1:0] rail_f_o,
    input logic [NB-1:0] dout_o,
    input logic          out_valid_o
);

    a_r1_eval_then_pre: assert property (@(posedge clk) disable iff (!rst_n)
        eval_o |=> !eval_o);

    a_r1_pre_then_eval: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_o |=> eval_o);

    a_r2_precharge_low: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_o |-> (rail_t_o == '0 && rail_f_o == '0));

    a_r3_one_rail_high: assert property (@(posedge clk) disable iff (!rst_n)
        eval_o |-> ((rail_t_o ^ rail_f_o) == '1 && (rail_t_o & rail_f_o) == '0));

    a_r4_unmasked_result: assert property (@(posedge clk) disable iff (!rst_n)
        eval_o |=> dout_o == ($past(rail_t_o) ^ {NB{$past(mask_o)}}));

    a_r5_valid_follows_eval: assert property (@(posedge clk) disable iff (!rst_n)
        eval_o |=> out_valid_o);

    a_r5_no_valid_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_o |=> !out_valid_o);

    a_r7_mask_steady: assert property (@(posedge clk) disable iff (!rst_n)
        eval_o |-> $stable(mask_o));

endmodule

bind masked_drp_sbox msbox_checker #(.NB(msbox_pkg::NBITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .eval_o      (eval_o),
    .mask_o      (mask_o),
    .rail_t_o    (rail_t_o),
    .rail_f_o    (rail_f_o),
    .dout_o      (dout_o),
    .out_valid_o (out_valid_o)
);

// File: tb/masked_drp_sbox_bench.sv
module masked_drp_sbox_bench;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    din = 4'h0;
    logic          eval_o;
    logic          mask_o;
    logic [3:0]    rail_t_o;
    logic [3:0]    rail_f_o;
    logic [3:0]    dout_o;
    logic          out_valid_o;
    logic [4*CW-1:0] cnt_t_o;
    logic [4*CW-1:0] cnt_f_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] mdl;
    int exp_t [4];
    int exp_f [4];
    int n_eval = 0;
    bit seen [16][2];

    always #10 clk = ~clk;

    masked_drp_sbox u_masked_drp_sbox (
        .clk(clk), .rst_n(rst_n), .din(din), .eval_o(eval_o), .mask_o(mask_o),
        .rail_t_o(rail_t_o), .rail_f_o(rail_f_o), .dout_o(dout_o),
        .out_valid_o(out_valid_o), .cnt_t_o(cnt_t_o), .cnt_f_o(cnt_f_o)
    );

    function automatic logic [3:0] ref_s(input logic [3:0] x);
        logic [3:0] tbl [16] = '{4'hC, 4'h5, 4'h6, 4'hB, 4'h9, 4'h0, 4'hA, 4'hD,
                                 4'h3, 4'hE, 4'hF, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};
        return tbl[x];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        mdl = 64'h0123_4567_89AB_CDEF;
        n_eval = 0;
        for (int i = 0; i < 4; i++) begin
            exp_t[i] = 0;
            exp_f[i] = 0;
        end
    endtask

    task automatic check_counters();
        for (int i = 0; i < 4; i++) begin
            chk(cnt_t_o[i*CW +: CW] == CW'(exp_t[i]), "R8 true-rail rise count",
                64'(cnt_t_o[i*CW +: CW]), 64'(exp_t[i]));
            chk(cnt_f_o[i*CW +: CW] == CW'(exp_f[i]), "R8 false-rail rise count",
                64'(cnt_f_o[i*CW +: CW]), 64'(exp_f[i]));
            chk(int'(cnt_t_o[i*CW +: CW]) + int'(cnt_f_o[i*CW +: CW]) == n_eval,
                "R8 rail sum equals evaluations",
                64'(int'(cnt_t_o[i*CW +: CW]) + int'(cnt_f_o[i*CW +: CW])), 64'(n_eval));
        end
    endtask

    // Apply reset for two cycles, release at a falling edge, check R9 and R1.
    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        chk(eval_o == 1'b0, "R1 precharge after reset", 64'(eval_o), 64'd0);
        chk(dout_o == 4'h0, "R9 dout cleared", 64'(dout_o), 64'd0);
        chk(out_valid_o == 1'b0, "R9 valid cleared", 64'(out_valid_o), 64'd0);
        chk(mask_o == mdl[0], "R9 mask seed reloaded", 64'(mask_o), 64'(mdl[0]));
        chk(cnt_t_o == '0 && cnt_f_o == '0, "R9 counters cleared",
            64'(cnt_t_o ^ cnt_f_o), 64'd0);
        chk(rail_t_o == 4'h0 && rail_f_o == 4'h0, "R2 rails low after reset",
            64'({rail_t_o, rail_f_o}), 64'd0);
    endtask

    // One precharge/evaluation pair; entered at a falling edge in precharge.
    task automatic run_one(input logic [3:0] x, input bit disturb);
        logic [3:0] y;
        logic       m;
        y = ref_s(x);
        din = x;
        @(posedge clk);
        @(negedge clk);
        m = mdl[0];
        chk(eval_o == 1'b1, "R1 evaluation follows precharge", 64'(eval_o), 64'd1);
        chk(mask_o == m, "R7 mask steady into evaluation", 64'(mask_o), 64'(m));
        chk(rail_t_o == (y ^ {4{m}}), "R3 true rails carry masked result",
            64'(rail_t_o), 64'(y ^ {4{m}}));
        chk(rail_f_o == ~rail_t_o, "R3 exactly one rail per pair",
            64'(rail_f_o), 64'(~rail_t_o));
        chk(out_valid_o == 1'b0, "R5 no valid during evaluation", 64'(out_valid_o), 64'd0);
        if (disturb) din = ~x;
        @(posedge clk);
        @(negedge clk);
        n_eval++;
        for (int i = 0; i < 4; i++) begin
            if (y[i] ^ m) exp_t[i]++;
            else exp_f[i]++;
        end
        mdl = {mdl[62:0], mdl[63] ^ mdl[62] ^ mdl[60] ^ mdl[59]};
        seen[x][m] = 1'b1;
        chk(eval_o == 1'b0, "R1 precharge follows evaluation", 64'(eval_o), 64'd0);
        chk(rail_t_o == 4'h0 && rail_f_o == 4'h0, "R2 rails low in precharge",
            64'({rail_t_o, rail_f_o}), 64'd0);
        chk(out_valid_o == 1'b1, "R5 valid pulse after evaluation", 64'(out_valid_o), 64'd1);
        chk(dout_o == y, disturb ? "R7 din ignored during evaluation" : "R4 substitution result",
            64'(dout_o), 64'(y));
        chk(mask_o == mdl[0], "R6 mask register step", 64'(mask_o), 64'(mdl[0]));
    endtask

    task automatic scenario_patterns();
        run_one(4'h0, 1'b0);
        run_one(4'hF, 1'b0);
        run_one(4'h5, 1'b1);
        run_one(4'hA, 1'b1);
        check_counters();
    endtask

    // Steer inputs using the known mask sequence until every (input, mask) pair is seen.
    task automatic scenario_full_cover();
        int guard = 0;
        bit all;
        all = 1'b0;
        while (!all && guard < 400) begin
            logic [3:0] pick;
            pick = 4'(guard);
            for (int k = 15; k >= 0; k--) begin
                if (!seen[k][mdl[0]]) pick = 4'(k);
            end
            run_one(pick, 1'b0);
            guard++;
            all = 1'b1;
            for (int k = 0; k < 16; k++) begin
                if (!seen[k][0] || !seen[k][1]) all = 1'b0;
            end
        end
        chk(all, "R4 all inputs under both mask values", 64'(all), 64'd1);
        check_counters();
    endtask

    task automatic scenario_hold();
        logic [3:0] held;
        held = dout_o;
        @(posedge clk);
        @(negedge clk);
        chk(dout_o == held, "R5 result held through evaluation", 64'(dout_o), 64'(held));
        chk(out_valid_o == 1'b0, "R5 valid is a single pulse", 64'(out_valid_o), 64'd0);
        @(posedge clk);
        @(negedge clk);
        n_eval++;
        for (int i = 0; i < 4; i++) begin
            if (ref_s(din)[i] ^ mdl[0]) exp_t[i]++;
            else exp_f[i]++;
        end
        mdl = {mdl[62:0], mdl[63] ^ mdl[62] ^ mdl[60] ^ mdl[59]};
        check_counters();
    endtask

    initial begin
        for (int k = 0; k < 16; k++) begin
            seen[k][0] = 1'b0;
            seen[k][1] = 1'b0;
        end
        model_reset();
        @(negedge clk);
        do_reset();
        scenario_patterns();
        scenario_full_cover();
        scenario_hold();
        do_reset();
        run_one(4'h9, 1'b0);
        check_counters();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule